// File: doc/BRIEF.md
# SPI Burst Regenerator

This block sits at the far end of a serial link and turns a stream of small frame payloads back into an SPI transaction on a local bus. Each payload carries a chip-select flag, a bit count and up to four data bits. Payloads arrive late and unevenly, so the block queues the data bits and clocks them out as bursts of SCLK pulses. Between bursts the bus stays idle.

Chip select is ordered against the data around it. An assert flag pulls the select line low before the first bit is clocked. A release flag does not take effect until every queued bit has left the block. The serial clock runs in mode 0: it idles low and MOSI is valid before each rising edge. The high and low phases of SCLK are set by a compile-time half-period.

Top module: `spi_burst_regen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `spi_cs_n` is 1, `spi_sclk` is 0 and `spi_mosi` is 0.
- R2: A payload with `frm_ss`=1 that is sampled at rising edge e drives `spi_cs_n` low by rising edge e+1.
- R3: Data bits leave the block in arrival order, one per SCLK pulse. Within a payload, `frm_data[0]` is sent first. Only the lowest `frm_cnt` bits are used, and any count above 4 counts as 4.
- R4: Each SCLK pulse stays high for exactly HALF_CYC clock cycles, and MOSI does not change while SCLK is high. Between two pulses, SCLK stays low for at least HALF_CYC cycles.
- R5: SCLK pulses only while `spi_cs_n` is low.
- R6: A payload with `frm_ss`=0 does not raise `spi_cs_n` while bits are still queued or being shifted. Once the queue and shifter are both empty, `spi_cs_n` rises.
- R7: Data bits in a payload with `frm_ss`=0 are discarded, and they produce no SCLK pulse.
- R8: A payload is queued only if all of its bits fit into the DEPTH-bit queue, counting the occupancy before that cycle's removal. If it does not fit, the whole payload is dropped.
- R9: A transaction whose bits are split across several payloads with gaps between them comes out as one contiguous bit stream under a single low period of `spi_cs_n`. A valid example is: select-only, then three bits, then the rest.
- R10: With no queued bits, SCLK stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | Payload strobe, one cycle per payload |
| frm_ss | input | 1 | Chip-select request: 1 = select, 0 = release |
| frm_cnt | input | 3 | Number of valid data bits (values above 4 count as 4) |
| frm_data | input | 4 | Data bits, bit 0 sent first |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |

## Verification
The bench builds the block with HALF_CYC=3 and DEPTH=16. A half-period of 3 separates the high-phase length from the single setup cycle, so a miscounted phase changes the measured pulse width. Because the queue holds 16 bits, four back-to-back full payloads fill it exactly, and a fifth reaches the drop rule. Random payload trains with random gaps produce the uneven bursts, the pending releases and the clamped counts.

// File: rtl/spi_regen_pkg.sv
package spi_regen_pkg;
  localparam int FRM_BITS  = 4;
  localparam int FRM_CNT_W = 3;
  localparam int PUSH_W    = $clog2(FRM_BITS + 1);

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_SETUP = 2'd1,
    SH_HIGH  = 2'd2,
    SH_LOW   = 2'd3
  } sh_state_t;
endpackage

// File: rtl/spi_frame_dec.sv
module spi_frame_dec
  import spi_regen_pkg::*;
(
  input  logic                 valid,
  input  logic                 ss,
  input  logic [FRM_CNT_W-1:0] cnt,
  input  logic [FRM_BITS-1:0]  data,
  output logic                 sel_set,
  output logic                 sel_clr,
  output logic [PUSH_W-1:0]    push_n,
  output logic [FRM_BITS-1:0]  push_bits
);
  // Payloads without a select request carry no usable data.
  always_comb begin
    sel_set   = valid && ss;
    sel_clr   = valid && !ss;
    push_bits = data;
    push_n    = '0;
    if (sel_set) begin
      if (int'(cnt) > FRM_BITS) push_n = PUSH_W'(FRM_BITS);
      else                      push_n = PUSH_W'(cnt);
    end
  end
endmodule

// File: rtl/spi_bit_queue.sv
module spi_bit_queue #(
  parameter int DEPTH  = 16,
  parameter int WR_MAX = 4,
  parameter int NW     = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NW-1:0]             push_n,
  input  logic [WR_MAX-1:0]         push_bits,
  input  logic                      pop,
  output logic                      head,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [DEPTH-1:0] store_q, store_d;
  logic [CW-1:0]    fill_q, fill_d;
  logic             fits;
  int               base;
  logic [IW-1:0]    idx;

  always_comb begin
    fits    = (int'(fill_q) + int'(push_n)) <= DEPTH;
    store_d = pop ? (store_q >> 1) : store_q;
    base    = int'(fill_q) - (pop ? 1 : 0);
    idx     = '0;
    for (int i = 0; i < WR_MAX; i++) begin
      if (fits && (i < int'(push_n)) && ((base + i) < DEPTH)) begin
        idx          = IW'(base + i);
        store_d[idx] = push_bits[i];
      end
    end
    fill_d = fill_q - CW'(pop) + (fits ? CW'(push_n) : CW'(0));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
      fill_q  <= '0;
    end else begin
      store_q <= store_d;
      fill_q  <= fill_d;
    end
  end

  assign head  = store_q[0];
  assign level = fill_q;
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter
  import spi_regen_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic avail,
  input  logic enable,
  input  logic head,
  output logic pop,
  output logic busy,
  output logic sclk,
  output logic mosi
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  sh_state_t     st;
  logic [HW-1:0] hc;
  logic          hc_last;

  assign hc_last = (hc == HW'(HALF_CYC - 1));
  assign pop     = ((st == SH_IDLE) || (st == SH_LOW && hc_last)) && avail && enable;
  assign busy    = (st != SH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SH_IDLE;
      hc   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: begin
          if (pop) begin
            mosi <= head;
            st   <= SH_SETUP;
          end
        end
        SH_SETUP: begin
          sclk <= 1'b1;
          hc   <= '0;
          st   <= SH_HIGH;
        end
        SH_HIGH: begin
          if (hc_last) begin
            sclk <= 1'b0;
            hc   <= '0;
            st   <= SH_LOW;
          end else begin
            hc <= hc + 1'b1;
          end
        end
        default: begin
          if (hc_last) begin
            hc <= '0;
            if (pop) begin
              mosi <= head;
              st   <= SH_SETUP;
            end else begin
              st <= SH_IDLE;
            end
          end else begin
            hc <= hc + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_burst_regen.sv
module spi_burst_regen
  import spi_regen_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HALF_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frm_valid,
  input  logic                 frm_ss,
  input  logic [FRM_CNT_W-1:0] frm_cnt,
  input  logic [FRM_BITS-1:0]  frm_data,
  output logic                 spi_cs_n,
  output logic                 spi_sclk,
  output logic                 spi_mosi
);
  localparam int LW = $clog2(DEPTH + 1);

  logic                sel_set, sel_clr;
  logic [PUSH_W-1:0]   push_n;
  logic [FRM_BITS-1:0] push_bits;
  logic                q_head, q_pop, sh_busy;
  logic [LW-1:0]       q_level;
  logic                ss_req, cs_n_q;

  spi_frame_dec u_dec (
    .valid     (frm_valid),
    .ss        (frm_ss),
    .cnt       (frm_cnt),
    .data      (frm_data),
    .sel_set   (sel_set),
    .sel_clr   (sel_clr),
    .push_n    (push_n),
    .push_bits (push_bits)
  );

  spi_bit_queue #(.DEPTH(DEPTH), .WR_MAX(FRM_BITS), .NW(PUSH_W)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .push_n    (push_n),
    .push_bits (push_bits),
    .pop       (q_pop),
    .head      (q_head),
    .level     (q_level)
  );

  spi_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .avail  (q_level != '0),
    .enable (!cs_n_q),
    .head   (q_head),
    .pop    (q_pop),
    .busy   (sh_busy),
    .sclk   (spi_sclk),
    .mosi   (spi_mosi)
  );

  // Select follows the latest request; release waits for an empty pipeline.
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_req <= 1'b0;
      cs_n_q <= 1'b1;
    end else begin
      if (sel_set)      ss_req <= 1'b1;
      else if (sel_clr) ss_req <= 1'b0;

      if (cs_n_q && ss_req)
        cs_n_q <= 1'b0;
      else if (!cs_n_q && !ss_req && !sel_set && (q_level == '0) && !sh_busy)
        cs_n_q <= 1'b1;
    end
  end

  assign spi_cs_n = cs_n_q;
endmodule

// File: rtl/spi_regen_chk.sv
module spi_regen_chk #(
  parameter int DEPTH    = 16,
  parameter int HALF_CYC = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_n,
  input logic                       sclk,
  input logic                       mosi,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       busy
);
  logic [15:0] hi_run;

  always_ff @(posedge clk) begin
    if (rst)       hi_run <= '0;
    else if (sclk) hi_run <= hi_run + 1'b1;
    else           hi_run <= '0;
  end

  p_reset_state_r1: assert property (@(posedge clk) rst |=> (cs_n && !sclk && !mosi));

  p_mosi_stable_r4: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_high_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_run == 16'(HALF_CYC)));

  p_sclk_needs_cs_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !cs_n);

  p_release_drained_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> ($past(level) == '0 && !$past(busy)));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    int'(level) <= DEPTH);

  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
endmodule

bind spi_burst_regen spi_regen_chk #(.DEPTH(DEPTH), .HALF_CYC(HALF_CYC)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs_n  (spi_cs_n),
  .sclk  (spi_sclk),
  .mosi  (spi_mosi),
  .level (q_level),
  .busy  (sh_busy)
);

// File: tb/sim_spi_burst_regen.sv
module sim_spi_burst_regen;
  localparam int HALF  = 3;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frm_valid = 1'b0;
  logic       frm_ss = 1'b0;
  logic [2:0] frm_cnt = '0;
  logic [3:0] frm_data = '0;
  logic       spi_cs_n, spi_sclk, spi_mosi;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit exp_q[$];

  always #4 clk = ~clk;

  spi_burst_regen #(.DEPTH(DEPTH), .HALF_CYC(HALF)) u0 (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_ss(frm_ss),
    .frm_cnt(frm_cnt), .frm_data(frm_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
  );

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int eff_cnt(input int c);
    return (c > 4) ? 4 : c;
  endfunction

  // Bench model: queue the bits a payload should deliver.
  task automatic model_push(input bit ss, input int c, input logic [3:0] d);
    if (ss) for (int i = 0; i < eff_cnt(c); i++) exp_q.push_back(d[i]);
  endtask

  task automatic send(input bit ss, input int c, input logic [3:0] d);
    @(negedge clk);
    frm_valid = 1'b1; frm_ss = ss; frm_cnt = 3'(c); frm_data = d;
    model_push(ss, c, d);
    @(negedge clk);
    frm_valid = 1'b0; frm_ss = 1'b0; frm_cnt = '0; frm_data = '0;
  endtask

  task automatic drain();
    while (!(spi_cs_n === 1'b1 && exp_q.size() == 0)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Output monitor
  logic prev_sclk = 1'b0, prev_cs = 1'b1, cap = 1'b0, seen_fall = 1'b0;
  int   hi_len = 0, lo_len = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_sclk && !prev_sclk) begin
        pulses++;
        chk("R5 cs_n during pulse", int'(spi_cs_n), 0);
        if (seen_fall && lo_len < HALF) chk("R4 low gap", lo_len, HALF);
        if (exp_q.size() == 0) chk("R3 unexpected pulse", 1, 0);
        else chk("R3 mosi bit", int'(spi_mosi), int'(exp_q.pop_front()));
        cap = spi_mosi;
        hi_len = 1;
      end else if (spi_sclk) begin
        hi_len++;
        if (spi_mosi !== cap) chk("R4 mosi moved", int'(spi_mosi), int'(cap));
      end
      if (!spi_sclk && prev_sclk) begin
        chk("R4 high width", hi_len, HALF);
        seen_fall = 1'b1;
        lo_len = 1;
      end else if (!spi_sclk) begin
        lo_len++;
      end
      if (spi_cs_n && !prev_cs) chk("R6 bits pending at release", exp_q.size(), 0);
      prev_sclk = spi_sclk;
      prev_cs   = spi_cs_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", int'(spi_cs_n), 1);
    chk("R1 sclk in reset", int'(spi_sclk), 0);
    chk("R1 mosi in reset", int'(spi_mosi), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n after reset", int'(spi_cs_n), 1);

    // R2 / R9: select only, then 3 bits, a gap, then the remainder
    send(1'b1, 0, 4'b0000);
    @(negedge clk);
    chk("R2 cs_n low", int'(spi_cs_n), 0);
    send(1'b1, 3, 4'b0101);
    repeat (25) @(negedge clk);
    send(1'b1, 4, 4'b1100);
    send(1'b1, 1, 4'b0001);
    send(1'b0, 0, 4'b0000);
    drain();
    chk("R9 stream complete", exp_q.size(), 0);
    chk("R9 cs_n released", int'(spi_cs_n), 1);

    // R7 / R10: release payload with data gives no pulses
    p0 = pulses;
    send(1'b0, 4, 4'b1111);
    repeat (30) @(negedge clk);
    chk("R7 no pulses", pulses, p0);
    chk("R7 cs_n stays high", int'(spi_cs_n), 1);
    chk("R10 sclk idle low", int'(spi_sclk), 0);

    // R3: a count above 4 is clamped to 4
    p0 = pulses;
    send(1'b1, 0, 4'b0000);
    send(1'b1, 7, 4'b1011);
    send(1'b0, 0, 4'b0000);
    drain();
    chk("R3 clamped count", pulses - p0, 4);

    // R6: release arrives right behind the data
    send(1'b1, 4, 4'b0110);
    send(1'b0, 0, 4'b0000);
    @(negedge clk);
    chk("R6 release held", int'(spi_cs_n), 0);
    drain();
    chk("R6 released after drain", int'(spi_cs_n), 1);

    // R8: five back-to-back full payloads, the fifth does not fit
    send(1'b1, 0, 4'b0000);
    repeat (2) @(negedge clk);
    p0 = pulses;
    for (int k = 0; k < 5; k++) begin
      logic [3:0] d;
      d = 4'($urandom);
      @(negedge clk);
      frm_valid = 1'b1; frm_ss = 1'b1; frm_cnt = 3'd4; frm_data = d;
      if (k < 4) model_push(1'b1, 4, d);
    end
    @(negedge clk);
    frm_valid = 1'b0; frm_ss = 1'b0; frm_cnt = '0; frm_data = '0;
    send(1'b0, 0, 4'b0000);
    drain();
    chk("R8 accepted bits", pulses - p0, 16);

    // Random payload trains
    for (int t = 0; t < 30; t++) begin
      int nf;
      send(1'b1, 0, 4'b0000);
      nf = 1 + int'($urandom % 5);
      for (int f = 0; f < nf; f++) begin
        while (exp_q.size() > 8) @(negedge clk);
        repeat (int'($urandom % 20)) @(negedge clk);
        send(1'b1, int'($urandom % 8), 4'($urandom));
      end
      send(1'b0, 0, 4'b0000);
      drain();
      chk("R9 random train complete", exp_q.size(), 0);
    end
    chk("R10 idle at end", int'(spi_sclk), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule